// File: doc/BRIEF.md
# Host Data FIFO with Flow Control

This block carries data between an external host on an 8-bit or 16-bit asynchronous bus and a 32-bit word interface on the chip's DMA side. A sixteen-entry word store sits between the two sides. It runs in one direction at a time. With the direction input low, the host writes beats, the block packs them into words, and the DMA side drains those words. With the direction input high, the DMA side fills words and the host reads them back beat by beat. Beat order inside a word can be little or big endian.

A single ready output tells the host when it may move data, and it has two modes. In acknowledge mode it drops after every data strobe and stretches the host cycle for a fixed minimum time. It stays low for longer if the access has to wait for space or for data. In interrupt mode it stays high during single accesses. It falls once when a whole store's worth of data can be moved: when the store is drained during host writes, or when it is filled during host reads. It rises again as soon as the host begins that block. Strobes that the host marks as configuration or status accesses never touch the data path or the ready output. A flush input throws away all stored words and any half-built word.

Top module: `host_fifo_bridge`

## Requirements
- R1: After reset, `hst_rdy` is 1, `hst_rdata` is 0, both error flags are 0 and `dma_out_valid` is 0.
- R2: With `wide16`=1, two host beats form one word. With `big_end`=0 the first beat lands in bits [15:0]. With `big_end`=1 it lands in bits [31:16].
- R3: With `wide16`=0, four host beats form one word. With `big_end`=0 the first beat lands in bits [7:0]. With `big_end`=1 it lands in bits [31:24]. Only `hst_wdata[7:0]` is used.
- R4: Host reads unpack each word with the same lane order as R2 and R3. In 8-bit mode, `hst_rdata[15:8]` reads as 0.
- R5: The store keeps words in arrival order and holds DEPTH (16) words. With 16 words held, `dma_in_ready` is 0.
- R6: Half duplex. With `dir_rd`=0, `dma_in_ready` is 0 and host read strobes are ignored. With `dir_rd`=1, `dma_out_valid` is 0 and host write strobes are ignored.
- R7: In acknowledge mode (`mode_ack`=1), `hst_rdy` is 0 from the cycle after an accepted data strobe and stays low for exactly WAIT (3) cycles when the access can be serviced at once.
- R8: In acknowledge mode, a write while 16 words are held, or a read while none is held, keeps `hst_rdy` low until the DMA side frees a word or supplies one. The access then completes with no loss.
- R9: In interrupt mode, `hst_rdy` falls once the block condition is reached: for writes, the store is empty with no partial word; for reads, 16 words are held. It rises after the next served host beat. It can only fall again after DEPTH times beats-per-word served beats.
- R10: In interrupt mode, a host write while 16 words are held is dropped and sets `ovf_flag`, which stays set until reset.
- R11: In interrupt mode, a host read while the store is empty leaves `hst_rdata` at its last value and sets `udf_flag`, which stays set until reset.
- R12: A strobe with `hst_cfg`=1 changes neither `hst_rdy`, the stored data, the packing state nor `hst_rdata`.
- R13: A one-cycle `flush` empties the store and discards any partly packed word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard all stored and partly packed data |
| mode_ack | input | 1 | 1: acknowledge (wait-state) flow control, 0: interrupt (block) flow control |
| dir_rd | input | 1 | 1: host reads, DMA side fills; 0: host writes, DMA side drains |
| wide16 | input | 1 | 1: 16-bit host beats, 0: 8-bit host beats |
| big_end | input | 1 | 1: first beat in the most significant lane |
| hst_wr | input | 1 | One-cycle host write strobe |
| hst_rd | input | 1 | One-cycle host read strobe |
| hst_cfg | input | 1 | 1: strobe addresses configuration/status, not data |
| hst_wdata | input | 16 | Host write beat |
| hst_rdata | output | 16 | Last host read beat |
| hst_rdy | output | 1 | Flow-control output to the host |
| ovf_flag | output | 1 | Sticky dropped-write flag |
| udf_flag | output | 1 | Sticky empty-read flag |
| dma_out_valid | output | 1 | Word available to the DMA side |
| dma_out_data | output | 32 | Word to the DMA side |
| dma_out_ready | input | 1 | DMA side takes the word |
| dma_in_valid | input | 1 | DMA side offers a word |
| dma_in_data | input | 32 | Word from the DMA side |
| dma_in_ready | output | 1 | Block accepts the word |

## Verification
Corrupted beat-index or packing state shows up at `dma_out_data` one word later as swapped or stale lanes. On the read side it appears at `hst_rdata` two cycles after the strobe. A bad occupancy count shows up quickly: `dma_in_ready` drops at the wrong fill level, a blocked acknowledge-mode access releases early or never, or the interrupt-mode edge fires at the wrong moment. A wrong block counter takes a full block to become visible, as a missing or extra falling edge on `hst_rdy`.

// File: rtl/hfb_pkg.sv
package hfb_pkg;

  // Pending host data access captured from a strobe
  typedef struct packed {
    logic        valid;
    logic        is_wr;
    logic [15:0] data;
  } hacc_t;

  // Bit offset of host lane for beat number idx inside a dw-bit word
  function automatic int unsigned lane_shift(input int unsigned idx, input logic wide,
                                             input logic big, input int unsigned dw);
    int unsigned w;
    int unsigned lanes;
    int unsigned lane;
    w     = wide ? 16 : 8;
    lanes = dw / w;
    lane  = big ? (lanes - 1 - idx) : idx;
    return lane * w;
  endfunction

endpackage

// File: rtl/hfb_store.sv
module hfb_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] count
);
  localparam int AW = $clog2(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  // storage array without reset so it maps to distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push) wr_ptr <= nxt(wr_ptr);
      if (pop)  rd_ptr <= nxt(rd_ptr);
      case ({push, pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end
endmodule

// File: rtl/hfb_lane.sv
module hfb_lane
  import hfb_pkg::*;
#(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          mode_ack,
  input  logic          dir_rd,
  input  logic          wide16,
  input  logic          big_end,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic          hst_cfg,
  input  logic [15:0]   hst_wdata,
  input  logic [CW-1:0] count,
  input  logic [DW-1:0] head,
  output logic          acc_new,
  output logic          acc_pend,
  output logic          acc_serve,
  output logic          beat_zero,
  output logic          host_push,
  output logic [DW-1:0] host_word,
  output logic          host_pop,
  output logic [15:0]   hst_rdata,
  output logic          ovf_flag,
  output logic          udf_flag
);
  localparam int BIW = $clog2(DW / 8);

  hacc_t           acc;
  logic [BIW-1:0]  idx;
  logic [BIW-1:0]  idx_last;
  logic [DW-1:0]   pack_q;
  logic [DW-1:0]   lane_mask, beat_ext, wr_word, rd_shift;
  logic [15:0]     rd_beat;
  logic            full, empty, can_move, done, at_last;
  int unsigned     shift;

  assign full      = (count == CW'(DEPTH));
  assign empty     = (count == '0);
  assign idx_last  = wide16 ? BIW'(DW / 16 - 1) : BIW'(DW / 8 - 1);
  assign at_last   = (idx == idx_last);
  assign beat_zero = (idx == '0);

  // a data strobe in the active direction, taken only when nothing is pending
  assign acc_new  = !flush && !acc.valid && !hst_cfg &&
                    ((hst_wr && !dir_rd) || (hst_rd && dir_rd));
  assign acc_pend = acc.valid;
  assign can_move = acc.is_wr ? !full : !empty;
  assign acc_serve = acc.valid && (can_move || !mode_ack);
  assign done     = acc_serve && can_move;

  assign shift     = lane_shift({{(32 - BIW){1'b0}}, idx}, wide16, big_end, DW);
  assign lane_mask = (wide16 ? DW'(16'hFFFF) : DW'(8'hFF)) << shift;
  assign beat_ext  = wide16 ? DW'(acc.data) : DW'(acc.data[7:0]);
  assign wr_word   = (pack_q & ~lane_mask) | (beat_ext << shift);
  assign rd_shift  = head >> shift;
  assign rd_beat   = wide16 ? rd_shift[15:0] : {8'h00, rd_shift[7:0]};

  assign host_push = done && acc.is_wr && at_last;
  assign host_word = wr_word;
  assign host_pop  = done && !acc.is_wr && at_last;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      acc    <= '0;
      idx    <= '0;
      pack_q <= '0;
    end else begin
      if (acc_new)        acc <= '{valid: 1'b1, is_wr: hst_wr, data: hst_wdata};
      else if (acc_serve) acc.valid <= 1'b0;
      if (done) begin
        idx <= at_last ? '0 : idx + 1'b1;
        if (acc.is_wr) pack_q <= wr_word;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hst_rdata <= '0;
      ovf_flag  <= 1'b0;
      udf_flag  <= 1'b0;
    end else if (!flush) begin
      if (done && !acc.is_wr)                   hst_rdata <= rd_beat;
      if (acc_serve && !can_move &&  acc.is_wr) ovf_flag  <= 1'b1;
      if (acc_serve && !can_move && !acc.is_wr) udf_flag  <= 1'b1;
    end
  end
endmodule

// File: rtl/hfb_flow.sv
module hfb_flow #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int WAIT  = 3,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          mode_ack,
  input  logic          dir_rd,
  input  logic          wide16,
  input  logic          acc_new,
  input  logic          acc_pend,
  input  logic          acc_serve,
  input  logic          beat_zero,
  input  logic [CW-1:0] count,
  output logic          hst_rdy
);
  localparam int WCW = $clog2(WAIT + 1);
  localparam int BKW = $clog2(DEPTH * DW / 8 + 1);

  logic [WCW-1:0] wcnt, wcnt_n;
  logic [BKW-1:0] blk, blk_last;
  logic           armed, pend_n, ack_rdy_n, cond;

  assign wcnt_n    = acc_new ? WCW'(WAIT) : ((wcnt != '0) ? wcnt - 1'b1 : '0);
  assign pend_n    = acc_new || (acc_pend && !acc_serve);
  assign ack_rdy_n = !pend_n && (wcnt_n == '0);

  assign cond     = dir_rd ? (count == CW'(DEPTH)) : ((count == '0) && beat_zero);
  assign blk_last = wide16 ? BKW'(DEPTH * DW / 16 - 1) : BKW'(DEPTH * DW / 8 - 1);

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      hst_rdy <= 1'b1;
      wcnt    <= '0;
      armed   <= 1'b1;
      blk     <= '0;
    end else begin
      wcnt <= wcnt_n;
      if (mode_ack) begin
        hst_rdy <= ack_rdy_n;
      end else if (acc_serve) begin
        hst_rdy <= 1'b1;
        if (blk == blk_last) begin
          blk   <= '0;
          armed <= 1'b1;
        end else begin
          blk <= blk + 1'b1;
        end
      end else if (armed && cond) begin
        hst_rdy <= 1'b0;
        armed   <= 1'b0;
        blk     <= '0;
      end
    end
  end
endmodule

// File: rtl/host_fifo_bridge.sv
module host_fifo_bridge #(
  parameter int DW    = 32,
  parameter int DEPTH = 16,
  parameter int WAIT  = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic          mode_ack,
  input  logic          dir_rd,
  input  logic          wide16,
  input  logic          big_end,
  input  logic          hst_wr,
  input  logic          hst_rd,
  input  logic          hst_cfg,
  input  logic [15:0]   hst_wdata,
  output logic [15:0]   hst_rdata,
  output logic          hst_rdy,
  output logic          ovf_flag,
  output logic          udf_flag,
  output logic          dma_out_valid,
  output logic [DW-1:0] dma_out_data,
  input  logic          dma_out_ready,
  input  logic          dma_in_valid,
  input  logic [DW-1:0] dma_in_data,
  output logic          dma_in_ready
);
  localparam int CW = $clog2(DEPTH + 1);

  logic [CW-1:0] count;
  logic [DW-1:0] head, host_word, st_data;
  logic          host_push, host_pop, st_push, st_pop;
  logic          acc_new, acc_pend, acc_serve, beat_zero;

  assign dma_out_valid = !dir_rd && (count != '0);
  assign dma_in_ready  = dir_rd && (count != CW'(DEPTH));
  assign dma_out_data  = head;

  assign st_push = dir_rd ? (dma_in_valid && dma_in_ready) : host_push;
  assign st_data = dir_rd ? dma_in_data : host_word;
  assign st_pop  = dir_rd ? host_pop : (dma_out_valid && dma_out_ready);

  hfb_store #(.DW(DW), .DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .flush(flush),
    .push(st_push), .push_data(st_data), .pop(st_pop),
    .head(head), .count(count)
  );

  hfb_lane #(.DW(DW), .DEPTH(DEPTH)) u_lane (
    .clk(clk), .rst(rst), .flush(flush),
    .mode_ack(mode_ack), .dir_rd(dir_rd), .wide16(wide16), .big_end(big_end),
    .hst_wr(hst_wr), .hst_rd(hst_rd), .hst_cfg(hst_cfg), .hst_wdata(hst_wdata),
    .count(count), .head(head),
    .acc_new(acc_new), .acc_pend(acc_pend), .acc_serve(acc_serve), .beat_zero(beat_zero),
    .host_push(host_push), .host_word(host_word), .host_pop(host_pop),
    .hst_rdata(hst_rdata), .ovf_flag(ovf_flag), .udf_flag(udf_flag)
  );

  hfb_flow #(.DW(DW), .DEPTH(DEPTH), .WAIT(WAIT)) u_flow (
    .clk(clk), .rst(rst), .flush(flush),
    .mode_ack(mode_ack), .dir_rd(dir_rd), .wide16(wide16),
    .acc_new(acc_new), .acc_pend(acc_pend), .acc_serve(acc_serve),
    .beat_zero(beat_zero), .count(count), .hst_rdy(hst_rdy)
  );
endmodule

// File: rtl/hfb_checker.sv
module hfb_checker (
  input logic clk,
  input logic rst,
  input logic flush,
  input logic mode_ack,
  input logic dir_rd,
  input logic hst_wr,
  input logic hst_cfg,
  input logic hst_rdy,
  input logic ovf_flag,
  input logic udf_flag,
  input logic dma_out_valid,
  input logic dma_in_ready
);
  // R7: accepted write strobe in acknowledge mode pulls ready low next cycle
  a_r7_ack_wait: assert property (@(posedge clk) disable iff (rst)
    mode_ack && hst_wr && !hst_cfg && !dir_rd && !flush && hst_rdy |=> !hst_rdy);

  // R6: no word offered to the DMA side while the host reads
  a_r6_out_dir: assert property (@(posedge clk) disable iff (rst)
    dma_out_valid |-> !dir_rd);

  // R6: no word accepted from the DMA side while the host writes
  a_r6_in_dir: assert property (@(posedge clk) disable iff (rst)
    dma_in_ready |-> dir_rd);

  // R10: overflow flag is sticky
  a_r10_ovf_sticky: assert property (@(posedge clk) disable iff (rst)
    ovf_flag |=> ovf_flag);

  // R11: underflow flag is sticky
  a_r11_udf_sticky: assert property (@(posedge clk) disable iff (rst)
    udf_flag |=> udf_flag);

  // R13: flush leaves nothing for the DMA side
  a_r13_flush_empty: assert property (@(posedge clk) disable iff (rst)
    flush |=> !dma_out_valid);

  // R8: acknowledge mode never drops a write
  a_r8_ack_no_drop: assert property (@(posedge clk) disable iff (rst)
    mode_ack && !ovf_flag |=> !ovf_flag);
endmodule

bind host_fifo_bridge hfb_checker u_chk (
  .clk(clk), .rst(rst), .flush(flush), .mode_ack(mode_ack), .dir_rd(dir_rd),
  .hst_wr(hst_wr), .hst_cfg(hst_cfg), .hst_rdy(hst_rdy),
  .ovf_flag(ovf_flag), .udf_flag(udf_flag),
  .dma_out_valid(dma_out_valid), .dma_in_ready(dma_in_ready)
);

// File: tb/host_fifo_bridge_tb.sv
`timescale 1ns/1ps
module host_fifo_bridge_tb;
  localparam int DW = 32, DEPTH = 16, WAIT = 3;

  logic clk = 1'b0;
  logic rst = 1'b1, flush = 1'b0, mode_ack = 1'b1, dir_rd = 1'b0, wide16 = 1'b1, big_end = 1'b0;
  logic hst_wr = 1'b0, hst_rd = 1'b0, hst_cfg = 1'b0;
  logic [15:0] hst_wdata = '0, hst_rdata;
  logic hst_rdy, ovf_flag, udf_flag, dma_out_valid, dma_in_ready;
  logic dma_out_ready = 1'b0, dma_in_valid = 1'b0;
  logic [DW-1:0] dma_out_data, dma_in_data = '0;

  int n_chk = 0, n_err = 0;

  always #4 clk = ~clk;

  host_fifo_bridge #(.DW(DW), .DEPTH(DEPTH), .WAIT(WAIT)) u_dut (
    .clk(clk), .rst(rst), .flush(flush), .mode_ack(mode_ack), .dir_rd(dir_rd),
    .wide16(wide16), .big_end(big_end), .hst_wr(hst_wr), .hst_rd(hst_rd),
    .hst_cfg(hst_cfg), .hst_wdata(hst_wdata), .hst_rdata(hst_rdata), .hst_rdy(hst_rdy),
    .ovf_flag(ovf_flag), .udf_flag(udf_flag), .dma_out_valid(dma_out_valid),
    .dma_out_data(dma_out_data), .dma_out_ready(dma_out_ready),
    .dma_in_valid(dma_in_valid), .dma_in_data(dma_in_data), .dma_in_ready(dma_in_ready)
  );

  function automatic logic [15:0] beat_of(input logic [31:0] w, input int i,
                                          input logic wd, input logic bg);
    int n, lane;
    n    = wd ? 2 : 4;
    lane = bg ? (n - 1 - i) : i;
    return wd ? w[lane*16 +: 16] : {8'h00, w[lane*8 +: 8]};
  endfunction

  function automatic int beats(input logic wd);
    return wd ? 2 : 4;
  endfunction

  task automatic check(input logic ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s act=%h exp=%h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(input logic ack, input logic rd, input logic wd, input logic bg);
    @(negedge clk);
    rst = 1'b1; mode_ack = ack; dir_rd = rd; wide16 = wd; big_end = bg;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic host_op(input logic wr, input logic cfg, input logic [15:0] d, output int low);
    @(negedge clk);
    hst_wr = wr; hst_rd = !wr; hst_cfg = cfg; hst_wdata = d;
    @(negedge clk);
    hst_wr = 1'b0; hst_rd = 1'b0; hst_cfg = 1'b0;
    low = 0;
    if (mode_ack) begin
      while (!hst_rdy) begin low++; @(negedge clk); end
    end else begin
      @(negedge clk);
    end
  endtask

  task automatic dma_push(input logic [31:0] w);
    @(negedge clk);
    while (!dma_in_ready) @(negedge clk);
    dma_in_valid = 1'b1; dma_in_data = w;
    @(negedge clk);
    dma_in_valid = 1'b0;
  endtask

  task automatic dma_pop(output logic [31:0] w);
    @(negedge clk);
    while (!dma_out_valid) @(negedge clk);
    w = dma_out_data; dma_out_ready = 1'b1;
    @(negedge clk);
    dma_out_ready = 1'b0;
  endtask

  task automatic write_word(input logic [31:0] w, output int low0);
    int low;
    for (int i = 0; i < beats(wide16); i++) begin
      host_op(1'b1, 1'b0, beat_of(w, i, wide16, big_end), low);
      if (i == 0) low0 = low;
    end
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL R1 watchdog act=timeout exp=finish");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] words [DEPTH];
    logic [31:0] got;
    logic [15:0] keep;
    int low;
    void'($urandom(32'h5EED));

    // R1 reset state
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    check(hst_rdy == 1'b1, "R1", "rdy", 32'(hst_rdy), 32'd1);
    check(hst_rdata == 16'h0, "R1", "rdata", 32'(hst_rdata), 32'd0);
    check(!ovf_flag && !udf_flag, "R1", "flags", {ovf_flag, udf_flag}, 32'd0);
    check(!dma_out_valid, "R1", "out_valid", 32'(dma_out_valid), 32'd0);

    // R2 R3 R5 R6 R7: acknowledge-mode host writes, all widths and orders
    for (int c = 0; c < 4; c++) begin
      do_reset(1'b1, 1'b0, c[0], c[1]);
      for (int k = 0; k < DEPTH; k++) begin
        words[k] = $urandom;
        write_word(words[k], low);
        if (k == 0) check(low == WAIT, "R7", "ack low cycles", low, WAIT);
      end
      check(!dma_in_ready, "R6", "in_ready while host writes", 32'(dma_in_ready), 32'd0);
      for (int k = 0; k < DEPTH; k++) begin
        dma_pop(got);
        if (wide16) check(got == words[k], "R2", "packed word", got, words[k]);
        else        check(got == words[k], "R3", "packed word", got, words[k]);
      end
    end

    // R4 R5 R6: acknowledge-mode host reads
    for (int c = 0; c < 4; c++) begin
      do_reset(1'b1, 1'b1, c[0], c[1]);
      for (int k = 0; k < DEPTH; k++) begin
        words[k] = $urandom;
        dma_push(words[k]);
      end
      @(negedge clk);
      check(!dma_in_ready, "R5", "in_ready when full", 32'(dma_in_ready), 32'd0);
      check(!dma_out_valid, "R6", "out_valid while host reads", 32'(dma_out_valid), 32'd0);
      for (int k = 0; k < DEPTH; k++)
        for (int i = 0; i < beats(wide16); i++) begin
          host_op(1'b0, 1'b0, 16'h0, low);
          check(hst_rdata == beat_of(words[k], i, wide16, big_end), "R4", "read beat",
                32'(hst_rdata), 32'(beat_of(words[k], i, wide16, big_end)));
        end
      // R12: status read leaves everything alone
      keep = hst_rdata;
      host_op(1'b0, 1'b1, 16'h0, low);
      check(low == 0 && hst_rdata == keep, "R12", "status read", {low[15:0], hst_rdata}, {16'h0, keep});
    end

    // R8: blocked read waits for data
    do_reset(1'b1, 1'b1, 1'b1, 1'b0);
    @(negedge clk); hst_rd = 1'b1;
    @(negedge clk); hst_rd = 1'b0;
    repeat (8) @(negedge clk);
    check(!hst_rdy, "R8", "rdy held on empty read", 32'(hst_rdy), 32'd0);
    words[0] = 32'hA5C3_1E0F;
    dma_push(words[0]);
    while (!hst_rdy) @(negedge clk);
    check(hst_rdata == 16'h1E0F, "R8", "released read data", 32'(hst_rdata), 32'h1E0F);

    // R8: blocked write waits for space
    do_reset(1'b1, 1'b0, 1'b1, 1'b0);
    for (int k = 0; k < DEPTH; k++) begin
      words[k] = $urandom;
      write_word(words[k], low);
    end
    @(negedge clk); hst_wr = 1'b1; hst_wdata = 16'hBEEF;
    @(negedge clk); hst_wr = 1'b0;
    repeat (8) @(negedge clk);
    check(!hst_rdy, "R8", "rdy held on full write", 32'(hst_rdy), 32'd0);
    dma_pop(got);
    check(got == words[0], "R8", "first word", got, words[0]);
    while (!hst_rdy) @(negedge clk);
    for (int k = 1; k < DEPTH; k++) begin
      dma_pop(got);
      check(got == words[k], "R8", "held word", got, words[k]);
    end
    host_op(1'b1, 1'b0, 16'h1234, low);
    dma_pop(got);
    check(got == 32'h1234_BEEF, "R8", "stalled beat kept", got, 32'h1234_BEEF);

    // R6: read strobe ignored while host writes; R12: config write ignored
    host_op(1'b0, 1'b0, 16'h0, low);
    check(low == 0, "R6", "wrong-direction strobe", low, 0);
    host_op(1'b1, 1'b1, 16'h7777, low);
    check(low == 0 && !dma_out_valid, "R12", "config write", {low[15:0], 15'h0, dma_out_valid}, 32'h0);
    host_op(1'b1, 1'b0, 16'h2222, low);
    host_op(1'b1, 1'b0, 16'h3333, low);
    dma_pop(got);
    check(got == 32'h3333_2222, "R12", "config data not packed", got, 32'h3333_2222);

    // R13: flush drops stored and partial words
    host_op(1'b1, 1'b0, 16'hAAAA, low);
    host_op(1'b1, 1'b0, 16'hBBBB, low);
    host_op(1'b1, 1'b0, 16'hCCCC, low);
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
    check(!dma_out_valid, "R13", "empty after flush", 32'(dma_out_valid), 32'd0);
    host_op(1'b1, 1'b0, 16'hDDDD, low);
    host_op(1'b1, 1'b0, 16'hEEEE, low);
    dma_pop(got);
    check(got == 32'hEEEE_DDDD, "R13", "partial discarded", got, 32'hEEEE_DDDD);

    // R9 R10: interrupt-mode host writes
    do_reset(1'b0, 1'b0, 1'b1, 1'b0);
    @(negedge clk);
    check(!hst_rdy, "R9", "fall on empty", 32'(hst_rdy), 32'd0);
    for (int k = 0; k < DEPTH; k++) begin
      words[k] = $urandom;
      write_word(words[k], low);
      if (k == 0) check(hst_rdy, "R9", "rise after first beat", 32'(hst_rdy), 32'd1);
    end
    check(hst_rdy, "R9", "high while full", 32'(hst_rdy), 32'd1);
    check(!ovf_flag, "R10", "no overflow yet", 32'(ovf_flag), 32'd0);
    host_op(1'b1, 1'b0, 16'hDEAD, low);
    check(ovf_flag, "R10", "overflow set", 32'(ovf_flag), 32'd1);
    for (int k = 0; k < DEPTH; k++) begin
      dma_pop(got);
      check(got == words[k], "R10", "dropped write absent", got, words[k]);
    end
    @(negedge clk);
    check(!hst_rdy, "R9", "fall after drain", 32'(hst_rdy), 32'd0);
    check(ovf_flag, "R10", "overflow sticky", 32'(ovf_flag), 32'd1);

    // R9 R11: interrupt-mode host reads, 8-bit big endian
    do_reset(1'b0, 1'b1, 1'b0, 1'b1);
    repeat (2) @(negedge clk);
    check(hst_rdy, "R9", "high while not full", 32'(hst_rdy), 32'd1);
    for (int k = 0; k < DEPTH; k++) begin
      words[k] = $urandom;
      dma_push(words[k]);
    end
    @(negedge clk);
    check(!hst_rdy, "R9", "fall on full", 32'(hst_rdy), 32'd0);
    for (int k = 0; k < DEPTH; k++)
      for (int i = 0; i < 4; i++) begin
        host_op(1'b0, 1'b0, 16'h0, low);
        check(hst_rdata == beat_of(words[k], i, 1'b0, 1'b1), "R4", "int read beat",
              32'(hst_rdata), 32'(beat_of(words[k], i, 1'b0, 1'b1)));
        if (k == 0 && i == 0) check(hst_rdy, "R9", "rise on first read", 32'(hst_rdy), 32'd1);
      end
    check(hst_rdy && !udf_flag, "R9", "stays high when empty", {hst_rdy, udf_flag}, 32'b10);
    keep = hst_rdata;
    host_op(1'b0, 1'b0, 16'h0, low);
    check(udf_flag, "R11", "underflow set", 32'(udf_flag), 32'd1);
    check(hst_rdata == keep, "R11", "last value kept", 32'(hst_rdata), 32'(keep));

    summary();
    $finish;
  end
endmodule